// File: doc/BRIEF.md
# Parallel Port Peripheral Handshake Engine

This block implements the peripheral end of the byte-wide extended-capabilities parallel link. It watches three handshake lines driven by the host: a host strobe, a host acknowledge and an active-low reverse request. It drives three lines back: a peripheral strobe, a peripheral acknowledge and an active-low reverse grant. It also owns an 8-bit data bus, presented as separate input, output and output-enable signals so that the pad ring can build the tristate.

While the host holds the link in the forward direction, the engine acknowledges each host strobe and captures the byte. It tags the byte as data or command from the level of the host acknowledge line, and presents it on a valid/ready output backed by a one-byte holding register. When the host has asked for the reverse direction, a byte offered on the valid/ready transmit input is driven onto the bus and strobed to the host. Afterwards the bus is returned to input. If the host changes direction in the middle of a cycle, the cycle is abandoned cleanly. All host lines pass through a synchroniser before the control logic sees them.

Top module: `ecp_periph_engine`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `periph_clk_o`=1, `periph_ack_o`=0, `ack_rev_n_o`=1, `bus_oe_o`=0, `rx_valid_o`=0 and `tx_ready_o`=0.
- R2: In forward direction (`host_rev_req_n_i`=1), the engine raises `periph_ack_o` after it sees `host_clk_i` low. It samples `bus_data_i` once it sees `host_clk_i` high again, then lowers `periph_ack_o` and presents the byte on `rx_byte_o` with `rx_valid_o`=1 until a cycle with `rx_ready_i`=1.
- R3: The tag `rx_is_cmd_o` is 0 when `host_ack_i` was high during the forward cycle (data), and 1 when it was low (command or channel address).
- R4: If `host_rev_req_n_i` goes low while the engine waits for `host_clk_i` to rise, `periph_ack_o` returns low and no byte is delivered.
- R5: A transmit request while `host_rev_req_n_i`=1 is completed at once with a one-cycle `tx_ready_o` and `tx_sent_o`=0. `ack_rev_n_o`, `bus_oe_o` and `periph_clk_o` do not move.
- R6: A reverse cycle proceeds in this order. First `ack_rev_n_o`=0, `bus_oe_o`=1, `bus_data_o` = the byte, and `periph_ack_o` = 1 for data (`tx_is_cmd_i`=0) or 0 for a command. Then `periph_clk_o` falls, and it rises only after `host_ack_i` is seen high.
- R7: When `host_ack_i` is seen low after that rise, the engine sets `bus_oe_o`=0, `periph_ack_o`=0 and `ack_rev_n_o`=1, and pulses `tx_ready_o` with `tx_sent_o`=1.
- R8: If `host_rev_req_n_i` goes high before `host_ack_i` has been seen high in a reverse cycle, the bus is released (`periph_clk_o`=1, `bus_oe_o`=0, `periph_ack_o`=0, `ack_rev_n_o`=1) and `tx_ready_o` pulses with `tx_sent_o`=0.
- R9: While the holding register contains an unaccepted byte, a new host strobe is not acknowledged (`periph_ack_o` stays 0) until the byte is taken.
- R10: With the default two synchroniser stages and the engine idle, `periph_ack_o` goes high on the third rising `clk` edge after `host_clk_i` falls, and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| host_clk_i | input | 1 | Host strobe |
| host_ack_i | input | 1 | Host acknowledge / forward data-command tag |
| host_rev_req_n_i | input | 1 | Host request for reverse direction, active low |
| periph_clk_o | output | 1 | Peripheral strobe |
| periph_ack_o | output | 1 | Peripheral acknowledge / reverse data-command tag |
| ack_rev_n_o | output | 1 | Reverse direction grant, active low |
| bus_data_i | input | 8 | Data bus as seen from the pins |
| bus_data_o | output | 8 | Data bus value to drive |
| bus_oe_o | output | 1 | Data bus output enable |
| rx_valid_o | output | 1 | Received byte available |
| rx_ready_i | input | 1 | Consumer takes the received byte |
| rx_byte_o | output | 8 | Received byte |
| rx_is_cmd_o | output | 1 | Received byte is a command |
| tx_valid_i | input | 1 | Byte offered for transmission |
| tx_ready_o | output | 1 | One-cycle completion of the offered byte |
| tx_byte_i | input | 8 | Byte to transmit |
| tx_is_cmd_i | input | 1 | Byte to transmit is a command |
| tx_sent_o | output | 1 | Qualifies tx_ready_o: 1 sent, 0 skipped or aborted |

## Verification
The assertions check the following on every cycle: the peripheral acknowledge rises in forward direction only after a low host strobe has been synchronised; the peripheral strobe never falls unless the bus is driven and the reverse grant is given; the grant is withdrawn only with the bus released; and the holding register is never loaded while full. The bench scenarios cover the properties that need a live host: the byte values and tags that come out, the three-edge synchroniser latency, abort in either direction, skipped transmits, and the withheld acknowledge under back-pressure.

// File: rtl/ecp_pkg.sv
package ecp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FWD_WAIT,
    ST_REV_DRIVE,
    ST_REV_WAIT_HI,
    ST_REV_WAIT_LO
  } eng_state_t;
endpackage

// File: rtl/ecp_sync.sv
module ecp_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/ecp_rx_hold.sv
module ecp_rx_hold #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic [DW-1:0] data_i,
  input  logic          cmd_i,
  input  logic          pop_i,
  output logic          full_o,
  output logic [DW-1:0] data_o,
  output logic          cmd_o
);
  logic          full_q;
  logic [DW-1:0] data_q;
  logic          cmd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      full_q <= 1'b0;
    end else if (load_i) begin
      full_q <= 1'b1;
    end else if (pop_i) begin
      full_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (load_i) begin
      data_q <= data_i;
      cmd_q  <= cmd_i;
    end
  end

  assign full_o = full_q;
  assign data_o = data_q;
  assign cmd_o  = cmd_q;

  // R9
  no_overwrite_chk: assert property (@(posedge clk) disable iff (rst)
    load_i |-> !full_q);
endmodule

// File: rtl/ecp_ctrl.sv
module ecp_ctrl
  import ecp_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hclk_s,
  input  logic          hack_s,
  input  logic          rreq_n_s,
  input  logic [DW-1:0] bus_in,
  input  logic          hold_full_i,
  output logic          load_o,
  output logic [DW-1:0] cap_data_o,
  output logic          cap_cmd_o,
  input  logic          tx_valid_i,
  input  logic [DW-1:0] tx_byte_i,
  input  logic          tx_cmd_i,
  output logic          tx_ready_o,
  output logic          tx_sent_o,
  output logic          periph_clk_o,
  output logic          periph_ack_o,
  output logic          ack_rev_n_o,
  output logic [DW-1:0] bus_out_o,
  output logic          bus_oe_o
);
  eng_state_t    state_q;
  logic          pclk_q, pack_q, arn_q, oe_q;
  logic          txr_q, txs_q, load_q, cmd_q;
  logic [DW-1:0] txd_q, cap_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      pclk_q  <= 1'b1;
      pack_q  <= 1'b0;
      arn_q   <= 1'b1;
      oe_q    <= 1'b0;
      txr_q   <= 1'b0;
      txs_q   <= 1'b0;
      load_q  <= 1'b0;
      cmd_q   <= 1'b0;
      txd_q   <= '0;
      cap_q   <= '0;
    end else begin
      txr_q  <= 1'b0;
      load_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          // R9: no acknowledge while the holding register is occupied
          if (rreq_n_s && !hclk_s && !hold_full_i && !load_q) begin
            pack_q  <= 1'b1;
            state_q <= ST_FWD_WAIT;
          end else if (tx_valid_i && !txr_q) begin
            if (!rreq_n_s) begin
              arn_q   <= 1'b0;
              oe_q    <= 1'b1;
              txd_q   <= tx_byte_i;
              pack_q  <= !tx_cmd_i;
              state_q <= ST_REV_DRIVE;
            end else begin
              // R5: forward direction, request skipped
              txr_q <= 1'b1;
              txs_q <= 1'b0;
            end
          end
        end
        ST_FWD_WAIT: begin
          if (!rreq_n_s) begin
            // R4: direction flipped, drop the cycle
            pack_q  <= 1'b0;
            state_q <= ST_IDLE;
          end else if (hclk_s) begin
            cap_q   <= bus_in;
            cmd_q   <= !hack_s;
            load_q  <= 1'b1;
            pack_q  <= 1'b0;
            state_q <= ST_IDLE;
          end
        end
        ST_REV_DRIVE, ST_REV_WAIT_HI: begin
          if (rreq_n_s) begin
            // R8: abort before the host acknowledged
            pclk_q  <= 1'b1;
            oe_q    <= 1'b0;
            pack_q  <= 1'b0;
            arn_q   <= 1'b1;
            txr_q   <= 1'b1;
            txs_q   <= 1'b0;
            state_q <= ST_IDLE;
          end else if (state_q == ST_REV_DRIVE) begin
            pclk_q  <= 1'b0;
            state_q <= ST_REV_WAIT_HI;
          end else if (hack_s) begin
            pclk_q  <= 1'b1;
            state_q <= ST_REV_WAIT_LO;
          end
        end
        ST_REV_WAIT_LO: begin
          if (!hack_s) begin
            oe_q    <= 1'b0;
            pack_q  <= 1'b0;
            arn_q   <= 1'b1;
            txr_q   <= 1'b1;
            txs_q   <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign load_o       = load_q;
  assign cap_data_o   = cap_q;
  assign cap_cmd_o    = cmd_q;
  assign tx_ready_o   = txr_q;
  assign tx_sent_o    = txs_q;
  assign periph_clk_o = pclk_q;
  assign periph_ack_o = pack_q;
  assign ack_rev_n_o  = arn_q;
  assign bus_out_o    = txd_q;
  assign bus_oe_o     = oe_q;

  // R2
  fwd_ack_cause_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(pack_q) && arn_q) |-> $past(!hclk_s && rreq_n_s));
  // R6
  strobe_needs_bus_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(pclk_q) |-> (!arn_q && oe_q));
  // R7
  grant_release_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(arn_q) |-> (!oe_q && !pack_q && pclk_q && txr_q));
  // R4
  capture_forward_chk: assert property (@(posedge clk) disable iff (rst)
    load_q |-> $past(rreq_n_s));
endmodule

// File: rtl/ecp_periph_engine.sv
module ecp_periph_engine #(
  parameter int DW = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          host_clk_i,
  input  logic          host_ack_i,
  input  logic          host_rev_req_n_i,
  output logic          periph_clk_o,
  output logic          periph_ack_o,
  output logic          ack_rev_n_o,
  input  logic [DW-1:0] bus_data_i,
  output logic [DW-1:0] bus_data_o,
  output logic          bus_oe_o,
  output logic          rx_valid_o,
  input  logic          rx_ready_i,
  output logic [DW-1:0] rx_byte_o,
  output logic          rx_is_cmd_o,
  input  logic          tx_valid_i,
  output logic          tx_ready_o,
  input  logic [DW-1:0] tx_byte_i,
  input  logic          tx_is_cmd_i,
  output logic          tx_sent_o
);
  localparam int NSYNC = 3;
  localparam logic [NSYNC-1:0] SYNC_IDLE = 3'b101;

  logic [NSYNC-1:0] raw_lines, sync_lines;
  logic             load, cap_cmd, hold_full;
  logic [DW-1:0]    cap_data;

  assign raw_lines = {host_rev_req_n_i, host_ack_i, host_clk_i};

  ecp_sync #(.W(NSYNC), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_IDLE)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (raw_lines),
    .q   (sync_lines)
  );

  ecp_ctrl #(.DW(DW)) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .hclk_s       (sync_lines[0]),
    .hack_s       (sync_lines[1]),
    .rreq_n_s     (sync_lines[2]),
    .bus_in       (bus_data_i),
    .hold_full_i  (hold_full),
    .load_o       (load),
    .cap_data_o   (cap_data),
    .cap_cmd_o    (cap_cmd),
    .tx_valid_i   (tx_valid_i),
    .tx_byte_i    (tx_byte_i),
    .tx_cmd_i     (tx_is_cmd_i),
    .tx_ready_o   (tx_ready_o),
    .tx_sent_o    (tx_sent_o),
    .periph_clk_o (periph_clk_o),
    .periph_ack_o (periph_ack_o),
    .ack_rev_n_o  (ack_rev_n_o),
    .bus_out_o    (bus_data_o),
    .bus_oe_o     (bus_oe_o)
  );

  ecp_rx_hold #(.DW(DW)) u_hold (
    .clk    (clk),
    .rst    (rst),
    .load_i (load),
    .data_i (cap_data),
    .cmd_i  (cap_cmd),
    .pop_i  (rx_ready_i && hold_full),
    .full_o (hold_full),
    .data_o (rx_byte_o),
    .cmd_o  (rx_is_cmd_o)
  );

  assign rx_valid_o = hold_full;

  // R1
  idle_levels_chk: assert property (@(posedge clk)
    $past(rst) |-> (periph_clk_o && !periph_ack_o && ack_rev_n_o && !bus_oe_o && !rx_valid_o && !tx_ready_o));
endmodule

// File: tb/test_ecp_periph_engine.sv
`timescale 1ns/1ps
module test_ecp_periph_engine;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst;
  logic       host_clk_i, host_ack_i, host_rev_req_n_i;
  logic       periph_clk_o, periph_ack_o, ack_rev_n_o;
  logic [7:0] bus_data_i, bus_data_o;
  logic       bus_oe_o;
  logic       rx_valid_o, rx_ready_i, rx_is_cmd_o;
  logic [7:0] rx_byte_o;
  logic       tx_valid_i, tx_ready_o, tx_is_cmd_i, tx_sent_o;
  logic [7:0] tx_byte_i;

  ecp_periph_engine i_ecp_periph_engine (
    .clk(clk), .rst(rst),
    .host_clk_i(host_clk_i), .host_ack_i(host_ack_i), .host_rev_req_n_i(host_rev_req_n_i),
    .periph_clk_o(periph_clk_o), .periph_ack_o(periph_ack_o), .ack_rev_n_o(ack_rev_n_o),
    .bus_data_i(bus_data_i), .bus_data_o(bus_data_o), .bus_oe_o(bus_oe_o),
    .rx_valid_o(rx_valid_o), .rx_ready_i(rx_ready_i), .rx_byte_o(rx_byte_o), .rx_is_cmd_o(rx_is_cmd_o),
    .tx_valid_i(tx_valid_i), .tx_ready_o(tx_ready_o), .tx_byte_i(tx_byte_i),
    .tx_is_cmd_i(tx_is_cmd_i), .tx_sent_o(tx_sent_o)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // expected tag and acknowledge level, from the requirements
  function automatic logic exp_rx_cmd(input logic host_ack_level);
    return !host_ack_level;
  endfunction
  function automatic logic exp_pack(input logic is_cmd);
    return !is_cmd;
  endfunction

  function automatic logic pick(input int w);
    case (w)
      0: return periph_ack_o;
      1: return periph_clk_o;
      2: return ack_rev_n_o;
      3: return tx_ready_o;
      4: return rx_valid_o;
      default: return 1'b0;
    endcase
  endfunction

  task automatic wait_for(input int w, input logic v, output bit ok);
    ok = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (pick(w) == v) begin ok = 1; break; end
    end
  endtask

  task automatic set_dir(input bit rev);
    @(negedge clk);
    host_ack_i = 1'b0;
    host_clk_i = 1'b1;
    host_rev_req_n_i = !rev;
    repeat (5) @(negedge clk);
  endtask

  task automatic host_fwd(input logic [7:0] b, input bit cmd, input string req);
    bit ok;
    @(negedge clk);
    bus_data_i = b;
    host_ack_i = !cmd;
    host_clk_i = 1'b0;
    wait_for(0, 1'b1, ok);
    chk({req, " ack raised"}, ok, 1);
    host_clk_i = 1'b1;
    wait_for(0, 1'b0, ok);
    chk({req, " ack dropped"}, ok, 1);
  endtask

  task automatic pop_rx(input logic [7:0] b, input bit cmd, input string req);
    bit ok;
    wait_for(4, 1'b1, ok);
    chk({req, " rx valid"}, ok, 1);
    chk({req, " rx byte"}, rx_byte_o, b);
    chk({req, " rx tag"}, rx_is_cmd_o, exp_rx_cmd(!cmd));
    rx_ready_i = 1'b1;
    @(posedge clk); #1;
    rx_ready_i = 1'b0;
  endtask

  task automatic host_rev(input logic [7:0] b, input bit cmd);
    bit ok;
    @(negedge clk);
    tx_byte_i = b; tx_is_cmd_i = cmd; tx_valid_i = 1'b1;
    wait_for(1, 1'b0, ok);
    chk("R6 strobe fell", ok, 1);
    chk("R6 data on bus", bus_data_o, b);
    chk("R6 bus driven", bus_oe_o, 1);
    chk("R6 grant", ack_rev_n_o, 0);
    chk("R6 tag level", periph_ack_o, exp_pack(cmd));
    repeat (3) @(negedge clk);
    chk("R6 strobe waits for host ack", periph_clk_o, 0);
    host_ack_i = 1'b1;
    wait_for(1, 1'b1, ok);
    chk("R6 strobe rose", ok, 1);
    host_ack_i = 1'b0;
    wait_for(3, 1'b1, ok);
    chk("R7 ready", ok, 1);
    chk("R7 sent", tx_sent_o, 1);
    chk("R7 released", {bus_oe_o, periph_ack_o, ack_rev_n_o}, 3'b001);
    @(posedge clk); #1;
    tx_valid_i = 1'b0;
  endtask

  task automatic tx_skip(input logic [7:0] b);
    bit ok;
    @(negedge clk);
    tx_byte_i = b; tx_is_cmd_i = 1'b0; tx_valid_i = 1'b1;
    wait_for(3, 1'b1, ok);
    chk("R5 ready", ok, 1);
    chk("R5 not sent", tx_sent_o, 0);
    chk("R5 lines still", {ack_rev_n_o, bus_oe_o, periph_clk_o}, 3'b101);
    @(posedge clk); #1;
    tx_valid_i = 1'b0;
  endtask

  task automatic summary;
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
  end

  initial begin
    bit ok;
    void'($urandom(32'd20240611));
    rst = 1'b1;
    host_clk_i = 1'b1; host_ack_i = 1'b0; host_rev_req_n_i = 1'b1;
    bus_data_i = 8'h00; rx_ready_i = 1'b0;
    tx_valid_i = 1'b0; tx_byte_i = 8'h00; tx_is_cmd_i = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset levels
    chk("R1 reset outputs", {periph_clk_o, periph_ack_o, ack_rev_n_o, bus_oe_o, rx_valid_o, tx_ready_o}, 6'b101000);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after release", {periph_clk_o, periph_ack_o, ack_rev_n_o, bus_oe_o, rx_valid_o, tx_ready_o}, 6'b101000);
    repeat (3) @(negedge clk);

    // R10 synchroniser latency
    bus_data_i = 8'h3c; host_ack_i = 1'b1; host_clk_i = 1'b0;
    @(posedge clk); @(posedge clk); #1;
    chk("R10 no ack before third edge", periph_ack_o, 0);
    @(posedge clk); #1;
    chk("R10 ack at third edge", periph_ack_o, 1);
    @(negedge clk); host_clk_i = 1'b1;
    wait_for(0, 1'b0, ok);
    pop_rx(8'h3c, 1'b0, "R10");

    // R2 data byte and R3 command byte
    host_fwd(8'ha5, 1'b0, "R2");
    pop_rx(8'ha5, 1'b0, "R2 R3 data");
    host_fwd(8'h5a, 1'b1, "R3");
    pop_rx(8'h5a, 1'b1, "R3 command");

    // R9 back-pressure
    host_fwd(8'h11, 1'b0, "R9 first");
    wait_for(4, 1'b1, ok);
    @(negedge clk);
    bus_data_i = 8'h22; host_ack_i = 1'b1; host_clk_i = 1'b0;
    ok = 1;
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (periph_ack_o) ok = 0; end
    chk("R9 ack withheld while full", ok, 1);
    pop_rx(8'h11, 1'b0, "R9 first");
    wait_for(0, 1'b1, ok);
    chk("R9 ack after pop", ok, 1);
    host_clk_i = 1'b1;
    wait_for(0, 1'b0, ok);
    pop_rx(8'h22, 1'b0, "R9 second");

    // R4 forward abort
    @(negedge clk);
    bus_data_i = 8'h77; host_ack_i = 1'b1; host_clk_i = 1'b0;
    wait_for(0, 1'b1, ok);
    host_rev_req_n_i = 1'b0;
    wait_for(0, 1'b0, ok);
    chk("R4 ack released", ok, 1);
    host_clk_i = 1'b1;
    repeat (10) @(negedge clk);
    chk("R4 no byte", rx_valid_o, 0);
    set_dir(1'b0);

    // R5 skip in forward direction
    tx_skip(8'h99);
    chk("R5 no byte appears", rx_valid_o, 0);

    // R6 R7 reverse data and command
    set_dir(1'b1);
    host_rev(8'hc3, 1'b0);
    host_rev(8'h0f, 1'b1);

    // R8 reverse abort
    @(negedge clk);
    tx_byte_i = 8'h44; tx_is_cmd_i = 1'b0; tx_valid_i = 1'b1;
    wait_for(1, 1'b0, ok);
    host_rev_req_n_i = 1'b1;
    wait_for(3, 1'b1, ok);
    chk("R8 ready", ok, 1);
    chk("R8 not sent", tx_sent_o, 0);
    chk("R8 released", {periph_clk_o, bus_oe_o, periph_ack_o, ack_rev_n_o}, 4'b1001);
    @(posedge clk); #1;
    tx_valid_i = 1'b0;
    repeat (5) @(negedge clk);

    // random mix
    for (int n = 0; n < 40; n++) begin
      int unsigned op;
      logic [7:0] b;
      bit c;
      op = $urandom % 4;
      b  = 8'($urandom);
      c  = 1'($urandom);
      case (op)
        0, 1: begin
          set_dir(1'b0);
          host_fwd(b, c, "R2 random");
          pop_rx(b, c, "R3 random");
        end
        2: begin
          set_dir(1'b1);
          host_rev(b, c);
        end
        default: begin
          set_dir(1'b0);
          tx_skip(b);
        end
      endcase
    end
    set_dir(1'b0);
    repeat (5) @(negedge clk);
    summary();
  end
endmodule